// File: doc/BRIEF.md
# SPI Master Slave-Select Controller

This block drives the single slave-select pin of an SPI master. It sits between the control register bits written by software and the shift engine that produces the serial clock and data. In automatic mode the block brackets each transfer. When software issues a start pulse, which is the go request that sets busy, the select line goes active. After a programmable setup interval the shift engine is launched. When the engine signals completion, the select line stays active for a programmable hold interval. Busy then self-clears and the line is released.

In manual mode the select line follows a software-written enable bit, and the transfer sequencing has no effect on it. In both modes the electrical level that means "asserted" comes from an active-level bit. The idle level is always the inverse of that level, including while reset is held. The shift engine and the register bus are outside the block and appear only as pulse and level inputs.

Top module: `spi_sel_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `sel_o` is at the inactive level (the inverse of `cfg_act_high`), and `busy_o` and `shift_go_o` are 0.
- R2: With `cfg_auto_en` = 0, `sel_o` shows the value of `cfg_sel_en` sampled at the previous clock edge, regardless of start or done activity.
- R3: The asserted level on `sel_o` is 1 when `cfg_act_high` = 1 and 0 when `cfg_act_high` = 0; the released level is the opposite.
- R4: With `cfg_auto_en` = 1 and `cfg_sel_en` = 1, a `start_i` pulse sampled while idle sets `busy_o` and drives `sel_o` active at that same clock edge.
- R5: With `cfg_auto_en` = 1 and `cfg_sel_en` = 0, `sel_o` remains at the inactive level through a whole transfer.
- R6: `shift_go_o` is high for exactly one cycle, starting LEAD_CYC clock edges after the edge at which `busy_o` rises; in automatic mode `sel_o` is active in that cycle.
- R7: After `xfer_done_i` is sampled, `sel_o` stays active for TRAIL_CYC more cycles; at the TRAIL_CYC-th edge after the done edge, `busy_o` falls and `sel_o` goes inactive together.
- R8: A `start_i` pulse sampled while `busy_o` is 1 is ignored: no second `shift_go_o` pulse, and `busy_o` falls at the time set by the first transfer.
- R9: A `xfer_done_i` pulse sampled while idle or during the setup interval is ignored: it neither sets nor shortens busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_auto_en | input | 1 | 1 = select timed by hardware, 0 = select follows `cfg_sel_en` |
| cfg_sel_en | input | 1 | Select enable (gates automatic select; drives select in manual mode) |
| cfg_act_high | input | 1 | 1 = select asserted high, 0 = asserted low |
| start_i | input | 1 | One-cycle go request from the register interface |
| xfer_done_i | input | 1 | One-cycle completion pulse from the shift engine |
| busy_o | output | 1 | Go/busy status, self-clearing |
| shift_go_o | output | 1 | One-cycle launch pulse to the shift engine |
| sel_o | output | 1 | Slave-select pin level |

## Verification
The main function is exercised with full automatic transfers at both polarities. This shows whether the assertion and release edges land on the edges that R4, R6 and R7 predict, and whether the level is inverted correctly. A transfer with the enable bit cleared, and a manual-mode transfer, show whether the select output is gated and whether it is decoupled from sequencing. Stray start pulses during a running transfer, and done pulses sent while idle or during setup, show that the sequencer accepts a request only in the state where it is legal.

// File: rtl/spi_sel_pkg.sv
// Shared types for the slave-select controller.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_sel_pkg;

    // Transfer phase as seen by the select logic.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_SHIFT = 2'd2,
        PH_HOLD  = 2'd3
    } xfer_phase_e;

    // Map a logical "asserted" flag to a pin level.
    function automatic logic to_pin(input logic asserted, input logic act_high);
        return act_high ? asserted : ~asserted;
    endfunction

endpackage

// File: rtl/spi_sel_timer.sv
// Saturating phase counter.
// Counts clock cycles spent in the current phase.
// Assumes: clr is pulsed on every phase change; MAX_CNT >= 1.
module spi_sel_timer #(
    parameter int MAX_CNT = 4,
    localparam int CW = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);

    // Purpose: count up from zero after each clear, stop at MAX_CNT.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != CW'(MAX_CNT)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CW'(MAX_CNT)); // R6

endmodule

// File: rtl/spi_sel_seq.sv
// Transfer sequencer.
// Runs IDLE -> SETUP -> SHIFT -> HOLD -> IDLE.
// SETUP lasts LEAD_CYC cycles and ends with a launch pulse to the shift engine.
// SHIFT waits for the done pulse. HOLD lasts TRAIL_CYC cycles.
// Assumes: start and done are single-cycle pulses; LEAD_CYC, TRAIL_CYC >= 1.
module spi_sel_seq
    import spi_sel_pkg::*;
#(
    parameter int LEAD_CYC  = 2,
    parameter int TRAIL_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        done_i,
    output xfer_phase_e phase_o,
    output logic        run_next_o,
    output logic        busy_o,
    output logic        shift_go_o
);

    localparam int MAXC = (LEAD_CYC > TRAIL_CYC) ? LEAD_CYC : TRAIL_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    xfer_phase_e phase_q, phase_d;
    logic [CW-1:0] cnt;
    logic          phase_last;

    spi_sel_timer #(.MAX_CNT(MAXC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_d != phase_q),
        .cnt_o (cnt)
    );

    // Purpose: flag the final cycle of a timed phase.
    always_comb begin
        case (phase_q)
            PH_SETUP: phase_last = (cnt == CW'(LEAD_CYC - 1));
            PH_HOLD:  phase_last = (cnt == CW'(TRAIL_CYC - 1));
            default:  phase_last = 1'b0;
        endcase
    end

    // Purpose: next-phase decision; start is honoured only in IDLE, done only in SHIFT.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (start_i)    phase_d = PH_SETUP;
            PH_SETUP: if (phase_last) phase_d = PH_SHIFT;
            PH_SHIFT: if (done_i)     phase_d = PH_HOLD;
            PH_HOLD:  if (phase_last) phase_d = PH_IDLE;
            default:                  phase_d = PH_IDLE;
        endcase
    end

    assign run_next_o = (phase_d != PH_IDLE);
    assign phase_o    = phase_q;

    // Purpose: phase register plus registered busy and launch outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            busy_o     <= 1'b0;
            shift_go_o <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            busy_o     <= run_next_o;
            shift_go_o <= (phase_q == PH_SETUP) && (phase_d == PH_SHIFT);
        end
    end

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R4
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go_o |=> !shift_go_o); // R6
    AST_START_IGNORED_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHIFT && start_i && !done_i) |=> (phase_q == PH_SHIFT)); // R8
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !start_i && done_i) |=> !busy_o); // R9

endmodule

// File: rtl/spi_sel_pin.sv
// Select pin driver.
// Registers the logical select state and applies the programmed polarity.
// Assumes: the polarity bit is quasi-static; during reset the pin is the inverse of the polarity bit.
module spi_sel_pin
    import spi_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic assert_next_i,
    input  logic act_high_i,
    output logic pin_o
);

    // Purpose: drive the inactive level in reset, otherwise the mapped level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o <= ~act_high_i;
        end else begin
            pin_o <= to_pin(assert_next_i, act_high_i);
        end
    end

    AST_RESET_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_o == ~$past(act_high_i))); // R1

endmodule

// File: rtl/spi_sel_ctrl.sv
// Slave-select controller for an SPI master (top).
// Automatic mode: select brackets each transfer launched by start_i.
// Manual mode: select follows cfg_sel_en.
// Assumes: one slave; shift engine accepts shift_go_o and returns xfer_done_i.
module spi_sel_ctrl
    import spi_sel_pkg::*;
#(
    parameter int LEAD_CYC  = 2,
    parameter int TRAIL_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_auto_en,
    input  logic cfg_sel_en,
    input  logic cfg_act_high,
    input  logic start_i,
    input  logic xfer_done_i,
    output logic busy_o,
    output logic shift_go_o,
    output logic sel_o
);

    xfer_phase_e phase;
    logic        run_next;
    logic        assert_next;

    spi_sel_seq #(.LEAD_CYC(LEAD_CYC), .TRAIL_CYC(TRAIL_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .done_i     (xfer_done_i),
        .phase_o    (phase),
        .run_next_o (run_next),
        .busy_o     (busy_o),
        .shift_go_o (shift_go_o)
    );

    // Purpose: choose the logical select source for the next cycle by mode.
    always_comb begin
        if (cfg_auto_en) begin
            assert_next = cfg_sel_en && run_next;
        end else begin
            assert_next = cfg_sel_en;
        end
    end

    spi_sel_pin u_pin (
        .clk           (clk),
        .rst_n         (rst_n),
        .assert_next_i (assert_next),
        .act_high_i    (cfg_act_high),
        .pin_o         (sel_o)
    );

    AST_MANUAL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_auto_en)) |->
        (sel_o == ($past(cfg_sel_en) ? $past(cfg_act_high) : ~$past(cfg_act_high)))); // R2
    AST_AUTO_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_auto_en) && !busy_o) |-> (sel_o == ~$past(cfg_act_high))); // R7
    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_auto_en) && !$past(cfg_sel_en)) |-> (sel_o == ~$past(cfg_act_high))); // R5
    AST_GO_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_go_o && $past(cfg_auto_en) && $past(cfg_sel_en)) |->
        (sel_o == $past(cfg_act_high))); // R6

endmodule

// File: tb/tb_spi_sel_ctrl.sv
module tb_spi_sel_ctrl;

    localparam int L = 2;
    localparam int T = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_auto_en = 1'b0, cfg_sel_en = 1'b0, cfg_act_high = 1'b0;
    logic start_i = 1'b0, xfer_done_i = 1'b0;
    logic busy_o, shift_go_o, sel_o;

    int n_chk = 0;
    int n_bad = 0;
    int go_cnt = 0;

    always #2.5 clk = ~clk;

    spi_sel_ctrl #(.LEAD_CYC(L), .TRAIL_CYC(T)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_auto_en(cfg_auto_en), .cfg_sel_en(cfg_sel_en),
        .cfg_act_high(cfg_act_high), .start_i(start_i), .xfer_done_i(xfer_done_i),
        .busy_o(busy_o), .shift_go_o(shift_go_o), .sel_o(sel_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
        if (shift_go_o) go_cnt++;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Full automatic transfer with edge-exact checks; act = expected asserted flag.
    task automatic run_xfer(input string tag, input logic act);
        logic on  = cfg_act_high ? act : ~act;
        logic off = ~cfg_act_high;
        start_i = 1'b1; step(); start_i = 1'b0;
        chk({tag, " R4 busy on start"}, busy_o, 1'b1);
        chk({tag, " R4 sel on start"}, sel_o, on);
        for (int i = 1; i < L; i++) begin
            step();
            chk({tag, " R6 no early go"}, shift_go_o, 1'b0);
        end
        step();
        chk({tag, " R6 go after setup"}, shift_go_o, 1'b1);
        chk({tag, " R6 sel during go"}, sel_o, on);
        step();
        chk({tag, " R6 go one cycle"}, shift_go_o, 1'b0);
        step();
        xfer_done_i = 1'b1; step(); xfer_done_i = 1'b0;
        for (int i = 1; i < T; i++) begin
            step();
            chk({tag, " R7 held after done"}, sel_o, on);
            chk({tag, " R7 busy held"}, busy_o, 1'b1);
        end
        step();
        chk({tag, " R7 busy clears"}, busy_o, 1'b0);
        chk({tag, " R7 sel released"}, sel_o, off);
    endtask

    task automatic t_reset();
        cfg_act_high = 1'b0; cfg_sel_en = 1'b1; cfg_auto_en = 1'b0;
        rst_n = 1'b0; step(); step();
        chk("R1 sel inactive in reset", sel_o, 1'b1);
        chk("R1 busy low", busy_o, 1'b0);
        chk("R1 go low", shift_go_o, 1'b0);
        cfg_sel_en = 1'b0; cfg_auto_en = 1'b1;
        rst_n = 1'b1; step();
        chk("R1 sel inactive after reset", sel_o, 1'b1);
    endtask

    task automatic t_manual(input logic pol);
        cfg_auto_en = 1'b0; cfg_act_high = pol; cfg_sel_en = 1'b1; step();
        chk("R2 R3 manual assert", sel_o, pol);
        cfg_sel_en = 1'b0; step();
        chk("R2 R3 manual release", sel_o, ~pol);
        start_i = 1'b1; step(); start_i = 1'b0;
        for (int i = 0; i < L + 2; i++) begin
            step();
            chk("R2 manual ignores transfer", sel_o, ~pol);
        end
        xfer_done_i = 1'b1; step(); xfer_done_i = 1'b0;
        for (int i = 0; i < T; i++) step();
        chk("R2 manual transfer ends", busy_o, 1'b0);
    endtask

    task automatic t_auto(input logic pol);
        cfg_auto_en = 1'b1; cfg_sel_en = 1'b1; cfg_act_high = pol; step();
        chk("R3 idle level", sel_o, ~pol);
        run_xfer(pol ? "auto-hi" : "auto-lo", 1'b1);
    endtask

    task automatic t_sel_off();
        cfg_auto_en = 1'b1; cfg_sel_en = 1'b0; cfg_act_high = 1'b1; step();
        start_i = 1'b1; step(); start_i = 1'b0;
        chk("R5 busy runs", busy_o, 1'b1);
        chk("R5 sel stays off", sel_o, 1'b0);
        for (int i = 0; i < L + 1; i++) begin
            step();
            chk("R5 sel off in transfer", sel_o, 1'b0);
        end
        xfer_done_i = 1'b1; step(); xfer_done_i = 1'b0;
        for (int i = 0; i < T; i++) step();
        chk("R5 sel off at end", sel_o, 1'b0);
        chk("R5 busy cleared", busy_o, 1'b0);
    endtask

    task automatic t_start_busy();
        cfg_auto_en = 1'b1; cfg_sel_en = 1'b1; cfg_act_high = 1'b0; step();
        go_cnt = 0;
        start_i = 1'b1; step(); start_i = 1'b0;
        start_i = 1'b1; step(); start_i = 1'b0;
        for (int i = 0; i < L + 2; i++) step();
        start_i = 1'b1; step(); start_i = 1'b0;
        chk("R8 one go only", go_cnt == 1, 1'b1);
        xfer_done_i = 1'b1; step(); xfer_done_i = 1'b0;
        start_i = 1'b1; step(); start_i = 1'b0;
        for (int i = 2; i < T; i++) step();
        step();
        chk("R8 busy ends on time", busy_o, 1'b0);
        chk("R8 sel released", sel_o, 1'b1);
        for (int i = 0; i < L + 2; i++) step();
        chk("R8 no go from ignored start", go_cnt == 1, 1'b1);
        chk("R8 still idle", busy_o, 1'b0);
    endtask

    task automatic t_done_ignored();
        cfg_auto_en = 1'b1; cfg_sel_en = 1'b1; cfg_act_high = 1'b1; step();
        xfer_done_i = 1'b1; step(); xfer_done_i = 1'b0;
        chk("R9 idle done no busy", busy_o, 1'b0);
        chk("R9 idle done no sel", sel_o, 1'b0);
        go_cnt = 0;
        start_i = 1'b1; step(); start_i = 1'b0;
        xfer_done_i = 1'b1; step(); xfer_done_i = 1'b0;
        for (int i = 2; i < L; i++) step();
        step();
        chk("R9 go despite setup done", shift_go_o, 1'b1);
        for (int i = 0; i < T + 2; i++) step();
        chk("R9 busy kept", busy_o, 1'b1);
        chk("R9 sel kept", sel_o, 1'b1);
        xfer_done_i = 1'b1; step(); xfer_done_i = 1'b0;
        for (int i = 0; i < T; i++) step();
        chk("R9 ends after real done", busy_o, 1'b0);
    endtask

    initial begin
        t_reset();
        t_manual(1'b1);
        t_manual(1'b0);
        t_auto(1'b1);
        t_auto(1'b0);
        t_sel_off();
        t_start_busy();
        t_done_ignored();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule